// File: doc/BRIEF.md
# Accumulator and Link Operate Microinstruction Unit

This block carries out the bit-programmed operate instruction of a small single-accumulator processor. It holds a 16-bit accumulator (AC) and a 1-bit link (L). Each set bit in the operate word enables one micro-operation. A single word may combine clearing, complementing, incrementing, rotating, merging the front-panel switch value, conditional skips and halting. The block applies the micro-operations in a fixed order, so the result of any combination is well defined.

The sequencer presents an operate word and the switch value and raises `start_i` for one cycle. One cycle later the block pulses `done_o`. On that cycle the updated AC and L are visible, `skip_o` tells the program-counter logic whether to skip the next word, and `halt_o` reports a halt request. Once halted, the block ignores further start strobes until reset.

Top module: `opr_micro_unit`

## Requirements
- R1: After reset, AC, L, `skip_o`, `halt_o` and `done_o` are all 0.
- R2: An accepted `start_i` (not halted) produces `done_o`=1 on the next cycle only, and `done_o` is 0 in every other cycle.
- R3: Operate word bit 0 clears AC, bit 1 clears L, bit 2 inverts AC and bit 3 inverts L. A clear takes effect before a complement, so bits 0 and 2 together give AC=FFFF.
- R4: Bit 4 adds one to AC after the clear and complement steps. A carry out of bit 15 inverts L, as in a 17-bit increment.
- R5: After the increment, bit 5 rotates the 17-bit value {L,AC} left by one and bit 6 rotates it right by one. When bits 5 and 6 are both set, no rotation takes place.
- R6: Bit 7 ORs `switch_i` into AC as the last step, after the rotation.
- R7: Bit 8 requests a skip when AC[15]=1, bit 9 when AC=0 and bit 10 when L=1. The enabled conditions are ORed and tested on AC and L as they were before the instruction. `skip_o` is valid with `done_o` and is 0 whenever `done_o` is 0.
- R8: Bit 11 sets `halt_o`, which stays set until reset. While `halt_o` is 1, `start_i` is ignored: no `done_o`, and AC and L do not change.
- R9: When no start is accepted, AC and L hold their values whatever `instr_i` and `switch_i` do.
- R10: Operate word bits 12 to 15 have no effect on AC, L, skip or halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle strobe: execute `instr_i` |
| instr_i | input | 16 | Operate word, one enable bit per micro-operation |
| switch_i | input | 16 | Front-panel switch value used by the OR step |
| ac_o | output | 16 | Accumulator |
| link_o | output | 1 | Link bit |
| skip_o | output | 1 | Skip request to the program-counter logic, valid with `done_o` |
| halt_o | output | 1 | Sticky halt flag |
| done_o | output | 1 | Completion pulse, one cycle after an accepted start |

## Verification
The hardest situations to reach are the ones that depend on AC and L already holding a particular value. One example is a skip that must be judged on the old AC while the same word changes it. Another is an increment carry that flips the link and is then rotated. Because AC can be loaded only through the operate words themselves, the vector table is an ordered chain. Each entry first builds the state the next entry needs (all ones, a lone link bit, a single set bit ready to rotate), and each entry's expected AC, L and skip follow from the one before. Directed steps after the table drive the halt lockout and reset.

// File: rtl/opr_pkg.sv
package opr_pkg;
  localparam int unsigned INSTR_W = 16;
  // enable bit positions inside the operate word
  localparam int unsigned B_CLR_AC = 0;
  localparam int unsigned B_CLR_LK = 1;
  localparam int unsigned B_INV_AC = 2;
  localparam int unsigned B_INV_LK = 3;
  localparam int unsigned B_INC    = 4;
  localparam int unsigned B_ROT_L  = 5;
  localparam int unsigned B_ROT_R  = 6;
  localparam int unsigned B_SW_OR  = 7;
  localparam int unsigned B_SK_NEG = 8;
  localparam int unsigned B_SK_ZER = 9;
  localparam int unsigned B_SK_LNK = 10;
  localparam int unsigned B_HALT   = 11;
  localparam int unsigned B_TOP    = B_HALT;

  typedef struct packed {
    logic clr_ac;
    logic clr_lk;
    logic inv_ac;
    logic inv_lk;
    logic inc;
    logic rot_l;
    logic rot_r;
    logic sw_or;
    logic sk_neg;
    logic sk_zer;
    logic sk_lnk;
    logic halt;
  } opr_ctl_t;
endpackage

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output opr_ctl_t           ctl_o
);
  logic unused_hi_bits;
  assign unused_hi_bits = ^instr_i[INSTR_W-1:B_TOP+1];

  always_comb begin
    ctl_o.clr_ac = instr_i[B_CLR_AC];
    ctl_o.clr_lk = instr_i[B_CLR_LK];
    ctl_o.inv_ac = instr_i[B_INV_AC];
    ctl_o.inv_lk = instr_i[B_INV_LK];
    ctl_o.inc    = instr_i[B_INC];
    ctl_o.rot_l  = instr_i[B_ROT_L];
    ctl_o.rot_r  = instr_i[B_ROT_R];
    ctl_o.sw_or  = instr_i[B_SW_OR];
    ctl_o.sk_neg = instr_i[B_SK_NEG];
    ctl_o.sk_zer = instr_i[B_SK_ZER];
    ctl_o.sk_lnk = instr_i[B_SK_LNK];
    ctl_o.halt   = instr_i[B_HALT];
  end
endmodule

// File: rtl/opr_alu_chain.sv
module opr_alu_chain
  import opr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  opr_ctl_t          ctl_i,
  input  logic [DATA_W-1:0] ac_i,
  input  logic              link_i,
  input  logic [DATA_W-1:0] sw_i,
  output logic [DATA_W-1:0] ac_o,
  output logic              link_o
);
  localparam int unsigned WIDE_W = DATA_W + 1;

  logic [DATA_W-1:0] ac_clr, ac_inv, ac_inc, ac_rot;
  logic              lk_clr, lk_inv, lk_inc, lk_rot;
  logic [WIDE_W-1:0] inc_sum;

  // stage 1: clears
  assign ac_clr = ctl_i.clr_ac ? '0 : ac_i;
  assign lk_clr = ctl_i.clr_lk ? 1'b0 : link_i;
  // stage 2: complements
  assign ac_inv = ctl_i.inv_ac ? ~ac_clr : ac_clr;
  assign lk_inv = ctl_i.inv_lk ? ~lk_clr : lk_clr;
  // stage 3: increment over the 17-bit {L,AC}
  assign inc_sum = {1'b0, ac_inv} + WIDE_W'(1);
  assign ac_inc  = ctl_i.inc ? inc_sum[DATA_W-1:0] : ac_inv;
  assign lk_inc  = ctl_i.inc ? (lk_inv ^ inc_sum[DATA_W]) : lk_inv;

  // stage 4: rotate; opposing directions cancel
  always_comb begin
    unique case ({ctl_i.rot_l, ctl_i.rot_r})
      2'b10: begin
        ac_rot = {ac_inc[DATA_W-2:0], lk_inc};
        lk_rot = ac_inc[DATA_W-1];
      end
      2'b01: begin
        ac_rot = {lk_inc, ac_inc[DATA_W-1:1]};
        lk_rot = ac_inc[0];
      end
      default: begin
        ac_rot = ac_inc;
        lk_rot = lk_inc;
      end
    endcase
  end

  // stage 5: switch merge
  assign ac_o   = ctl_i.sw_or ? (ac_rot | sw_i) : ac_rot;
  assign link_o = lk_rot;
endmodule

// File: rtl/opr_skip_eval.sv
module opr_skip_eval
  import opr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  opr_ctl_t          ctl_i,
  input  logic [DATA_W-1:0] ac_i,
  input  logic              link_i,
  output logic              skip_o
);
  logic neg_hit, zer_hit, lnk_hit;

  assign neg_hit = ctl_i.sk_neg & ac_i[DATA_W-1];
  assign zer_hit = ctl_i.sk_zer & (ac_i == '0);
  assign lnk_hit = ctl_i.sk_lnk & link_i;
  assign skip_o  = neg_hit | zer_hit | lnk_hit;
endmodule

// File: rtl/opr_micro_unit.sv
module opr_micro_unit
  import opr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [INSTR_W-1:0]  instr_i,
  input  logic [DATA_W-1:0]   switch_i,
  output logic [DATA_W-1:0]   ac_o,
  output logic                link_o,
  output logic                skip_o,
  output logic                halt_o,
  output logic                done_o
);
  opr_ctl_t          ctl;
  logic [DATA_W-1:0] ac_q, ac_d, ac_calc;
  logic              link_q, link_d, link_calc;
  logic              skip_q, skip_d, skip_calc;
  logic              halt_q, halt_d;
  logic              done_q, done_d;
  logic              accept;

  opr_decode u_decode (
    .instr_i (instr_i),
    .ctl_o   (ctl)
  );

  opr_alu_chain #(.DATA_W(DATA_W)) u_chain (
    .ctl_i  (ctl),
    .ac_i   (ac_q),
    .link_i (link_q),
    .sw_i   (switch_i),
    .ac_o   (ac_calc),
    .link_o (link_calc)
  );

  opr_skip_eval #(.DATA_W(DATA_W)) u_skip (
    .ctl_i  (ctl),
    .ac_i   (ac_q),
    .link_i (link_q),
    .skip_o (skip_calc)
  );

  assign accept = start_i & ~halt_q;

  // next state
  always_comb begin
    ac_d   = ac_q;
    link_d = link_q;
    halt_d = halt_q;
    done_d = accept;
    skip_d = accept & skip_calc;
    if (accept) begin
      ac_d   = ac_calc;
      link_d = link_calc;
      halt_d = halt_q | ctl.halt;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q   <= '0;
      link_q <= 1'b0;
      skip_q <= 1'b0;
      halt_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ac_q   <= ac_d;
      link_q <= link_d;
      skip_q <= skip_d;
      halt_q <= halt_d;
      done_q <= done_d;
    end
  end

  assign ac_o   = ac_q;
  assign link_o = link_q;
  assign skip_o = skip_q;
  assign halt_o = halt_q;
  assign done_o = done_q;

  // R2: completion pulse follows an accepted start
  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !halt_o) |=> done_o);
  // R2: no completion without an accepted start
  a_r2_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_i && !halt_o) |=> !done_o);
  // R3: clear then complement yields all ones
  a_r3_clear_then_inv: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !halt_o && instr_i[B_CLR_AC] && instr_i[B_INV_AC] &&
     !instr_i[B_INC] && !instr_i[B_ROT_L] && !instr_i[B_ROT_R] && !instr_i[B_SW_OR])
    |=> (ac_o == '1));
  // R7: skip only alongside completion
  a_r7_skip_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |-> done_o);
  // R8: halt is sticky
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> halt_o);
  // R8: halted machine keeps AC and L
  a_r8_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> ($stable(ac_o) && $stable(link_o)));
  // R9: idle cycles keep AC and L
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(ac_o) && $stable(link_o)));
endmodule

// File: tb/opr_micro_unit_tb.sv
module opr_micro_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [15:0] switch_i = '0;
  logic [15:0] ac_o;
  logic        link_o, skip_o, halt_o, done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  opr_micro_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
    .switch_i(switch_i), .ac_o(ac_o), .link_o(link_o), .skip_o(skip_o),
    .halt_o(halt_o), .done_o(done_o)
  );

  localparam int N = 16;
  localparam logic [15:0] T_INSTR [N] = '{
    16'h0081, 16'h0300, 16'h0007, 16'h0310, 16'h0602, 16'h00A1, 16'h0020, 16'h0040,
    16'h0040, 16'h0060, 16'h000C, 16'h0019, 16'h0014, 16'h0030, 16'hF004, 16'h0504};
  localparam logic [15:0] T_SW [N] = '{
    16'h1234, 16'hFFFF, 16'h0F0F, 16'h0000, 16'h0000, 16'h8001, 16'hFFFF, 16'h0000,
    16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000};
  localparam logic [15:0] T_AC [N] = '{
    16'h1234, 16'h1234, 16'hFFFF, 16'h0000, 16'h0000, 16'h8001, 16'h0002, 16'h8001,
    16'h4000, 16'h4000, 16'hBFFF, 16'h0001, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000};
  localparam logic T_LK [N] = '{
    1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0,
    1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic T_SK [N] = '{
    1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam int T_TAG [N] = '{6, 7, 3, 4, 7, 6, 5, 5, 5, 5, 3, 4, 4, 4, 10, 7};

  function automatic string tag_name(int k);
    case (k)
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one operate word; returns at the negedge where done is visible
  task automatic run_op(logic [15:0] ins, logic [15:0] sw);
    @(negedge clk);
    instr_i  = ins;
    switch_i = sw;
    start_i  = 1'b1;
    @(negedge clk);
    start_i  = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "ac", 32'(ac_o), 32'h0);
    check("R1", "link", 32'(link_o), 32'h0);
    check("R1", "skip", 32'(skip_o), 32'h0);
    check("R1", "halt", 32'(halt_o), 32'h0);
    check("R1", "done", 32'(done_o), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "done after release", 32'(done_o), 32'h0);

    for (int i = 0; i < N; i++) begin
      run_op(T_INSTR[i], T_SW[i]);
      check("R2", "done pulse", 32'(done_o), 32'h1);
      check(tag_name(T_TAG[i]), $sformatf("ac vec%0d", i), 32'(ac_o), 32'(T_AC[i]));
      check(tag_name(T_TAG[i]), $sformatf("link vec%0d", i), 32'(link_o), 32'(T_LK[i]));
      check(tag_name(T_TAG[i]), $sformatf("skip vec%0d", i), 32'(skip_o), 32'(T_SK[i]));
      check("R10", "no halt from table", 32'(halt_o), 32'h0);
      @(negedge clk);
      check("R2", "done drops", 32'(done_o), 32'h0);
      check("R7", "skip only with done", 32'(skip_o), 32'h0);
    end

    // R9: AC=FFFF then idle with a clearing word on the inputs
    run_op(16'h0004, 16'h0000);
    check("R9", "setup ac", 32'(ac_o), 32'hFFFF);
    instr_i  = 16'h0003;
    switch_i = 16'h5555;
    repeat (3) @(negedge clk);
    check("R9", "ac held idle", 32'(ac_o), 32'hFFFF);
    check("R9", "link held idle", 32'(link_o), 32'h0);
    check("R2", "no done idle", 32'(done_o), 32'h0);

    // R8: halt with complement and increment in the same word
    run_op(16'h0814, 16'h0000);
    check("R8", "halt set", 32'(halt_o), 32'h1);
    check("R8", "done on halt word", 32'(done_o), 32'h1);
    check("R8", "ac on halt word", 32'(ac_o), 32'h0001);
    run_op(16'h0004, 16'h0000);
    check("R8", "start ignored done", 32'(done_o), 32'h0);
    check("R8", "start ignored ac", 32'(ac_o), 32'h0001);
    check("R8", "halt stays", 32'(halt_o), 32'h1);

    // R1: reset clears halt and state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "ac after reset", 32'(ac_o), 32'h0);
    check("R1", "halt after reset", 32'(halt_o), 32'h0);
    rst_n = 1'b1;
    run_op(16'h0004, 16'h0000);
    check("R8", "runs after reset", 32'(ac_o), 32'hFFFF);
    finish_run();
  end
endmodule